// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Delayed Common Clear

This block compares a divided reference stream with a feedback stream and produces the two steering levels that a charge pump would consume. Both inputs are plain logic levels, sampled on a fast clock. Each rising edge becomes a single-cycle event. The reference events first pass through a programmable divider with a 14-bit ratio. A divided reference event raises `up`, and a feedback event raises `dn`. Once both are high, they stay high together for a programmed number of sample-clock cycles and are then cleared together. Because of this forced overlap, an arbitrarily small phase error still yields pulses of finite width, so the detector has no dead zone.

An edge that arrives during the forced overlap is kept and applied in the cycle after the clear, so no event is lost. A lock monitor measures the high time of `up` and of `dn` over each comparison. It raises `locked` after 16 consecutive comparisons with a small enough mismatch.

Top module: `pfd_antibacklash`

## Requirements
- R1: After `rst` is released, `up`, `dn` and `locked` are all 0 until the first input edge.
- R2: Only every Nth rising edge of `ref_in` becomes a reference event, where N is `ref_ratio` (1 to 16383). A value of 0 acts as 1. The divider count starts at zero after reset.
- R3: A reference event sets `up` and a feedback rising edge sets `dn`. Each level stays set until the common clear. A further edge on the same input while only its own output is high has no effect.
- R4: While `up` and `dn` are both high, they clear together after exactly D cycles of overlap. `ovl_sel` values 0, 1, 2 and 3 give D = 1, 2, 4 and 8.
- R5: Both input paths have equal latency. For a feedback edge lagging the reference edge by k sample cycles (k may be negative), the high time of `up` minus the high time of `dn` equals k. The later of the two outputs is high for exactly D cycles.
- R6: An edge that arrives while both outputs are high is held. Its output rises in the cycle after the clear.
- R7: A comparison ends at each common clear. `locked` rises at the clear that completes 16 consecutive comparisons whose width difference has magnitude at most D+1. It falls at the first clear whose comparison fails that test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference level input |
| fb_in | input | 1 | Feedback divider level input |
| ref_ratio | input | 14 | Reference division ratio (0 acts as 1) |
| ovl_sel | input | 2 | Overlap width code (1, 2, 4 or 8 cycles) |
| up | output | 1 | Reference-leads steering level |
| dn | output | 1 | Feedback-leads steering level |
| locked | output | 1 | Lock indicator |

## Verification
The main ports show internal faults within a single comparison:
- A divider count that is off by one moves the first `up` rise by a whole reference edge.
- A wrong overlap count changes the width of the later pulse at once.
- Unequal path latency shifts the signed width difference away from the applied lag.
- A dropped held edge leaves `up` low after the clear, when it should be high.

Lock faults appear only at comparison boundaries: a miscounted streak moves the rise of `locked` by one comparison. For that reason, the bench checks the lock indicator both after the 15th and after the 16th qualifying comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int OVL_CODE_W = 2;
  localparam int OVL_MAX    = 8;
  localparam int OVL_CNT_W  = $clog2(OVL_MAX + 1);

  function automatic logic [OVL_CNT_W-1:0] ovl_cycles(input logic [OVL_CODE_W-1:0] code);
    ovl_cycles = OVL_CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/edge_strobe.sv
module edge_strobe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic stb
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], lvl_in};
  end

  assign stb = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R3: an edge yields one event, never two in a row
  p_single_event_r3: assert property (@(posedge clk) disable iff (rst) stb |=> !stb);
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int RATIO_W = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_stb,
  input  logic [RATIO_W-1:0] ratio,
  output logic               out_stb
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] last;

  assign last    = (ratio == '0) ? '0 : ratio - RATIO_W'(1);
  assign out_stb = in_stb && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (out_stb) cnt_q <= '0;
    else if (in_stb)  cnt_q <= cnt_q + RATIO_W'(1);
  end

  // R2: a divided event only on an input event
  p_div_needs_input_r2: assert property (@(posedge clk) disable iff (rst) out_stb |-> in_stb);
  // R2: count restarts after each divided event
  p_div_restart_r2: assert property (@(posedge clk) disable iff (rst) out_stb |=> cnt_q == '0);
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_stb,
  input  logic                  fb_stb,
  input  logic [OVL_CODE_W-1:0] ovl_sel,
  output logic                  up,
  output logic                  dn,
  output logic                  clr_evt
);
  logic                 pend_up_q, pend_dn_q;
  logic [OVL_CNT_W-1:0] ovl_q;
  logic [OVL_CNT_W-1:0] lim;
  logic                 both;

  assign lim     = ovl_cycles(ovl_sel);
  assign both    = up && dn;
  assign clr_evt = both && ((ovl_q + OVL_CNT_W'(1)) >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0; dn <= 1'b0;
      pend_up_q <= 1'b0; pend_dn_q <= 1'b0;
      ovl_q <= '0;
    end else if (clr_evt) begin
      up <= pend_up_q || ref_stb;
      dn <= pend_dn_q || fb_stb;
      pend_up_q <= 1'b0; pend_dn_q <= 1'b0;
      ovl_q <= '0;
    end else if (both) begin
      if (ref_stb) pend_up_q <= 1'b1;
      if (fb_stb)  pend_dn_q <= 1'b1;
      ovl_q <= ovl_q + OVL_CNT_W'(1);
    end else begin
      if (ref_stb) up <= 1'b1;
      if (fb_stb)  dn <= 1'b1;
      ovl_q <= '0;
    end
  end

  // R3: up rises only from a reference event or a held one
  p_up_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(up) |-> $past(ref_stb || pend_up_q));
  // R3: dn rises only from a feedback event or a held one
  p_dn_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dn) |-> $past(fb_stb || pend_dn_q));
  // R4: overlap never runs past the longest code
  p_overlap_bound_r4: assert property (@(posedge clk) disable iff (rst)
    both |-> ovl_q < OVL_CNT_W'(OVL_MAX));
  // R6: a held edge is applied right after the clear
  p_pending_applied_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && pend_up_q) |=> up);
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
  import pfd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LOCK_N = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  up,
  input  logic                  dn,
  input  logic                  clr_evt,
  input  logic [OVL_CODE_W-1:0] ovl_sel,
  output logic                  locked
);
  localparam int LC_W = $clog2(LOCK_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] uw_q, dw_q;
  logic [CNT_W:0]   uw_t, dw_t, mag, tol;
  logic [LC_W-1:0]  run_q;
  logic             pass;

  assign uw_t = {1'b0, uw_q} + (CNT_W+1)'(up);
  assign dw_t = {1'b0, dw_q} + (CNT_W+1)'(dn);
  assign mag  = (uw_t >= dw_t) ? uw_t - dw_t : dw_t - uw_t;
  assign tol  = (CNT_W+1)'(ovl_cycles(ovl_sel)) + (CNT_W+1)'(1);
  assign pass = mag <= tol;

  always_ff @(posedge clk) begin
    if (rst) begin
      uw_q <= '0; dw_q <= '0; run_q <= '0; locked <= 1'b0;
    end else if (clr_evt) begin
      uw_q <= '0; dw_q <= '0;
      if (pass) begin
        if (run_q < LC_W'(LOCK_N)) run_q <= run_q + LC_W'(1);
        locked <= (run_q + LC_W'(1)) >= LC_W'(LOCK_N);
      end else begin
        run_q  <= '0;
        locked <= 1'b0;
      end
    end else begin
      if (up && uw_q != CNT_MAX) uw_q <= uw_q + CNT_W'(1);
      if (dn && dw_q != CNT_MAX) dw_q <= dw_q + CNT_W'(1);
    end
  end

  // R7: lock changes only at the end of a comparison
  p_lock_at_compare_r7: assert property (@(posedge clk) disable iff (rst)
    (locked != $past(locked)) |-> $past(clr_evt));
  // R7: a failing comparison removes lock
  p_fail_unlocks_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !pass) |=> !locked);
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash
  import pfd_pkg::*;
#(
  parameter int RATIO_W     = 14,
  parameter int SYNC_STAGES = 2,
  parameter int WIDTH_CNT_W = 16,
  parameter int LOCK_N      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_in,
  input  logic               fb_in,
  input  logic [RATIO_W-1:0] ref_ratio,
  input  logic [1:0]         ovl_sel,
  output logic               up,
  output logic               dn,
  output logic               locked
);
  logic ref_raw_stb, ref_div_stb, fb_stb, clr_evt;

  edge_strobe #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst(rst), .lvl_in(ref_in), .stb(ref_raw_stb));

  edge_strobe #(.STAGES(SYNC_STAGES)) u_fb_edge (
    .clk(clk), .rst(rst), .lvl_in(fb_in), .stb(fb_stb));

  ref_divider #(.RATIO_W(RATIO_W)) u_ref_div (
    .clk(clk), .rst(rst), .in_stb(ref_raw_stb), .ratio(ref_ratio), .out_stb(ref_div_stb));

  pfd_core u_core (
    .clk(clk), .rst(rst), .ref_stb(ref_div_stb), .fb_stb(fb_stb),
    .ovl_sel(ovl_sel), .up(up), .dn(dn), .clr_evt(clr_evt));

  lock_monitor #(.CNT_W(WIDTH_CNT_W), .LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst(rst), .up(up), .dn(dn), .clr_evt(clr_evt),
    .ovl_sel(ovl_sel), .locked(locked));

  // R1: outputs idle in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk) $past(rst) |-> (!up && !dn && !locked));
endmodule

// File: tb/pfd_antibacklash_bench.sv
module pfd_antibacklash_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic [13:0] ref_ratio = 14'd1;
  logic [1:0]  ovl_sel = 2'd0;
  logic up, dn, locked;

  int errors = 0, checks = 0;
  int upw, dnw, bth;
  bit done = 0;

  always #2 clk = ~clk;

  pfd_antibacklash u_pfd_antibacklash (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .ref_ratio(ref_ratio), .ovl_sel(ovl_sel), .up(up), .dn(dn), .locked(locked));

  function automatic int dval(input logic [1:0] c);
    return 1 << c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // pulses start at cycle offsets ra, rb (reference) and fa (feedback); -1 = none
  task automatic run_win(input int ra, input int rb, input int fa);
    int last = imax(imax(ra, rb), fa);
    int len = last + dval(ovl_sel) + 14;
    upw = 0; dnw = 0; bth = 0;
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      upw += int'(up); dnw += int'(dn); bth += int'(up && dn);
      ref_in = ((ra >= 0 && j >= ra && j < ra + 2) || (rb >= 0 && j >= rb && j < rb + 2));
      fb_in  = (fa >= 0 && j >= fa && j < fa + 2);
    end
  endtask

  task automatic run_lag(input int k);
    if (k >= 0) run_win(0, -1, k);
    else        run_win(-k, -1, 0);
  endtask

  task automatic ref_pulse();
    @(negedge clk); ref_in = 1'b1;
    @(negedge clk);
    @(negedge clk); ref_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1 reset state
    check("R1 up", int'(up), 0);
    check("R1 dn", int'(dn), 0);
    check("R1 locked", int'(locked), 0);

    // R2 divider ratio 5
    ref_ratio = 14'd5; do_reset();
    for (int i = 0; i < 4; i++) ref_pulse();
    repeat (4) @(negedge clk);
    check("R2 no event before 5th edge", int'(up), 0);
    ref_pulse(); repeat (4) @(negedge clk);
    check("R2 event on 5th edge", int'(up), 1);
    // R2 ratio 0 acts as 1
    ref_ratio = 14'd0; do_reset();
    ref_pulse(); repeat (4) @(negedge clk);
    check("R2 ratio zero as one", int'(up), 1);
    ref_ratio = 14'd1;

    // R4/R5 directed lags for each code
    for (int c = 0; c < 4; c++) begin
      ovl_sel = 2'(c); do_reset();
      run_lag(0);
      check("R4 simultaneous overlap", bth, dval(ovl_sel));
      check("R5 simultaneous diff", upw - dnw, 0);
      run_lag(5);
      check("R5 lag diff", upw - dnw, 5);
      check("R5 later width", dnw, dval(ovl_sel));
      run_lag(-7);
      check("R5 lead diff", upw - dnw, -7);
      check("R4 overlap lead", bth, dval(ovl_sel));
    end

    // R3 repeated reference edge ignored while only up is high
    ovl_sel = 2'd1; do_reset();
    run_win(0, 6, 12);
    check("R3 repeat ignored up width", upw, 12 + 2);
    check("R3 repeat ignored dn width", dnw, 2);
    check("R3 idle after", int'(up || dn), 0);

    // R6 edge during overlap is held
    ovl_sel = 2'd3; do_reset();
    run_win(0, 4, 0);
    check("R6 held up", int'(up), 1);
    check("R6 dn cleared", int'(dn), 0);
    run_win(-1, -1, 0);
    check("R6 held pulse cleared", int'(up || dn), 0);

    // R7 lock streak with D=2, tolerance 3
    ovl_sel = 2'd1; do_reset();
    for (int i = 0; i < 15; i++) run_lag((i % 2) ? 3 : -3);
    check("R7 not locked after 15", int'(locked), 0);
    run_lag(1);
    check("R7 locked after 16", int'(locked), 1);
    run_lag(-2);
    check("R7 stays locked", int'(locked), 1);
    run_lag(4);
    check("R7 unlock on bad compare", int'(locked), 0);

    // R5 random lags and codes
    for (int i = 0; i < 40; i++) begin
      int k;
      ovl_sel = 2'($urandom_range(3, 0));
      k = int'($urandom_range(30, 0)) - 15;
      run_lag(k);
      check("R5 random diff", upw - dnw, k);
      check("R4 random overlap", bth, dval(ovl_sel));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule